// File: doc/BRIEF.md
# Real-Power Extraction Datapath

This block turns two signed sample streams, one from a current sensor and one from a line-voltage sensor, into a filtered real-power word. Each accepted sample pair passes through three stages. First, a first-order high-pass section strips the DC offset from the current sample; the voltage sample is not filtered. Second, the cleaned current is multiplied at full precision by the voltage sample, delayed one cycle so that the two stay aligned. Third, a first-order low-pass section with guard bits keeps the DC term of that product, which is the real power.

The low-pass pole sits at a few hertz. The twice-line ripple that every multiplication of two sinusoids produces is therefore strongly attenuated. The average of the output equals V·I·cos(φ)/2, summed over every harmonic present in both channels, at any phase angle. Both filter coefficients are powers of two. The pole positions follow from `HPF_SHIFT`, `LPF_SHIFT` and the sample rate, so no multiplier is needed outside the power product.

Top module: `rp_power_path`

## Requirements
- R1: While `rst_n` is low and after its release, `pwr_valid` is 0 and `pwr_word` is 0 until the first accepted sample has propagated.
- R2: A sample pair accepted with `smp_valid` high at clock edge k produces exactly one `pwr_valid` pulse at edge k+3, and `pwr_valid` is never high without such a sample.
- R3: In cycles with `smp_valid` low the sample inputs are ignored and `pwr_word` keeps its value.
- R4: A constant current input with a sinusoidal voltage gives a settled real-power output of zero (within 1% of V·I/2), because DC is removed from the current channel.
- R5: Adding a DC offset to the current samples does not change the settled mean output by more than 1% of V·I/2, even when the voltage channel also carries an offset.
- R6: The instantaneous power is the signed full-width product of the high-passed current and the aligned voltage sample; its sign is the XOR of the operand signs, and it is zero when either operand is zero.
- R7: With sinusoidal current of peak I lagging voltage of peak V by φ, the settled mean of `pwr_word` is V·I·cos(φ)/2 within 1% of V·I/2. The mean is negative for φ above 90° and zero at 90°.
- R8: With a fundamental plus a third harmonic in both channels, the settled mean is the sum of the per-harmonic terms Vh·Ih·cos(φh)/2.
- R9: The low-pass output never moves away from its input: it does not fall while the product is above it and does not rise while the product is below it. With `LPF_SHIFT` = 6 and a ripple period of 32 samples, the peak-to-peak output ripple is below 20% of V·I/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample pair is present on both channels |
| cur_smp | input | SMP_W | Signed current-channel sample |
| vol_smp | input | SMP_W | Signed voltage-channel sample |
| pwr_valid | output | 1 | `pwr_word` was updated this cycle |
| pwr_word | output | 2*SMP_W (+2 without saturation) | Signed filtered real power |

## Verification
The bench builds the block with 16-bit samples, `HPF_SHIFT` = 12, `LPF_SHIFT` = 6, 8 guard bits and current saturation on. It uses a 64-sample line period. With these values the high-pass corner is about 400 times below the line frequency, so its phase lead stays under 0.2°. The low-pass time constant is 64 samples, so each phase, offset and harmonic case settles in about 12,000 samples. The twice-line ripple is damped by roughly 22 dB, which makes the ripple bound and the cos(φ) means measurable within the cycle budget. Means are taken over one full line period, so all integer harmonics of the product cancel exactly.

// File: rtl/rp_pkg.sv
package rp_pkg;
   // Width of the current path after DC removal: saturated back to the
   // sample width, or kept wide enough for any difference of two samples.
   function automatic int hpf_out_width(input int smp_w, input bit sat);
      return sat ? smp_w : smp_w + 2;
   endfunction

   function automatic int prod_width(input int smp_w, input bit sat);
      return hpf_out_width(smp_w, sat) + smp_w;
   endfunction
endpackage

// File: rtl/rp_dc_block.sv
module rp_dc_block #(
   parameter int SMP_W = 16,
   parameter int SHIFT = 13,
   parameter bit SAT   = 1'b1,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [SMP_W-1:0] in_smp,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_smp
);
   localparam int S_W = SMP_W + SHIFT + 2;
   localparam int D_W = SMP_W + 2;

   if (OUT_W != rp_pkg::hpf_out_width(SMP_W, SAT)) begin : g_bad_outw
      $error("rp_dc_block: OUT_W does not match SMP_W and SAT");
   end

   logic signed [S_W-1:0]   acc_q;
   logic signed [S_W-1:0]   acc_shr;
   logic signed [S_W-1:0]   diff_ext;
   logic signed [D_W-1:0]   x_ext;
   logic signed [D_W-1:0]   dc_est;
   logic signed [D_W-1:0]   diff;
   logic signed [OUT_W-1:0] y_d;

   assign x_ext    = in_smp;
   assign acc_shr  = acc_q >>> SHIFT;
   assign dc_est   = acc_shr[D_W-1:0];
   assign diff     = x_ext - dc_est;
   assign diff_ext = diff;

   if (SAT) begin : g_sat
      localparam logic signed [D_W-1:0] Y_MAX = D_W'((1 <<< (SMP_W - 1)) - 1);
      localparam logic signed [D_W-1:0] Y_MIN = -D_W'(1 <<< (SMP_W - 1));
      always_comb begin
         if (diff > Y_MAX)
            y_d = Y_MAX[OUT_W-1:0];
         else if (diff < Y_MIN)
            y_d = Y_MIN[OUT_W-1:0];
         else
            y_d = diff[OUT_W-1:0];
      end
   end else begin : g_wide
      assign y_d = diff[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         out_valid <= 1'b0;
         out_smp   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            acc_q   <= acc_q + diff_ext;
            out_smp <= y_d;
         end
      end
   end

   AST_HPF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_smp)); // R3
endmodule

// File: rtl/rp_mult.sv
module rp_mult #(
   parameter int A_W = 16,
   parameter int B_W = 16,
   parameter int P_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic signed [A_W-1:0] a,
   input  logic signed [B_W-1:0] b,
   output logic                  out_valid,
   output logic signed [P_W-1:0] p
);
   if (P_W != A_W + B_W) begin : g_bad_pw
      $error("rp_mult: P_W must equal A_W + B_W");
   end

   logic signed [P_W-1:0] prod_d;
   assign prod_d = a * b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         p         <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) p <= prod_d;
      end
   end

   AST_PROD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(a) != 0 && $past(b) != 0)
         |-> (p[P_W-1] == ($past(a[A_W-1]) ^ $past(b[B_W-1])))); // R6
   AST_PROD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($past(a) == 0 || $past(b) == 0)) |-> (p == 0)); // R6
endmodule

// File: rtl/rp_pole_lpf.sv
module rp_pole_lpf #(
   parameter int IN_W  = 32,
   parameter int SHIFT = 14,
   parameter int GUARD = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_p,
   output logic                   out_valid,
   output logic signed [IN_W-1:0] out_p
);
   localparam int Z_W = IN_W + GUARD + 1;

   logic signed [Z_W-1:0] z_q;
   logic signed [Z_W:0]   p_ext;
   logic signed [Z_W:0]   p_scaled;
   logic signed [Z_W:0]   z_ext;
   logic signed [Z_W:0]   delta;
   logic signed [Z_W:0]   step;
   logic signed [Z_W-1:0] z_out_shr;

   assign p_ext     = in_p;
   assign p_scaled  = p_ext <<< GUARD;
   assign z_ext     = z_q;
   assign delta     = p_scaled - z_ext;
   assign step      = delta >>> SHIFT;
   assign z_out_shr = z_q >>> GUARD;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z_q       <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) z_q <= z_q + step[Z_W-1:0];
      end
   end

   assign out_p = z_out_shr[IN_W-1:0];

   AST_LPF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_p > out_p) |=> (out_p >= $past(out_p))); // R9
   AST_LPF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_p < out_p) |=> (out_p <= $past(out_p))); // R9
   AST_LPF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_p)); // R3
endmodule

// File: rtl/rp_power_path.sv
module rp_power_path #(
   parameter int SMP_W     = 16,
   parameter int HPF_SHIFT = 13,
   parameter int LPF_SHIFT = 14,
   parameter int GUARD_W   = 8,
   parameter bit SAT_CUR   = 1'b1
) (
   input  logic                                                clk,
   input  logic                                                rst_n,
   input  logic                                                smp_valid,
   input  logic signed [SMP_W-1:0]                             cur_smp,
   input  logic signed [SMP_W-1:0]                             vol_smp,
   output logic                                                pwr_valid,
   output logic signed [rp_pkg::prod_width(SMP_W, SAT_CUR)-1:0] pwr_word
);
   localparam int HC_W   = rp_pkg::hpf_out_width(SMP_W, SAT_CUR);
   localparam int PROD_W = rp_pkg::prod_width(SMP_W, SAT_CUR);

   if (SMP_W < 4 || SMP_W > 24) begin : g_bad_smp
      $error("rp_power_path: SMP_W out of range 4..24");
   end
   if (HPF_SHIFT < 2 || HPF_SHIFT > 20) begin : g_bad_hpf
      $error("rp_power_path: HPF_SHIFT out of range 2..20");
   end
   if (LPF_SHIFT < 1 || LPF_SHIFT > 20) begin : g_bad_lpf
      $error("rp_power_path: LPF_SHIFT out of range 1..20");
   end
   if (GUARD_W < LPF_SHIFT / 2) begin : g_bad_guard
      $error("rp_power_path: GUARD_W too small for LPF_SHIFT");
   end

   logic                    hc_valid;
   logic signed [HC_W-1:0]  hc_smp;
   logic signed [SMP_W-1:0] vol_q;
   logic                    pr_valid;
   logic signed [PROD_W-1:0] pr_word;

   rp_dc_block #(
      .SMP_W (SMP_W),
      .SHIFT (HPF_SHIFT),
      .SAT   (SAT_CUR),
      .OUT_W (HC_W)
   ) u_dc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (smp_valid),
      .in_smp    (cur_smp),
      .out_valid (hc_valid),
      .out_smp   (hc_smp)
   );

   // Voltage travels one register alongside the high-pass stage.
   always_ff @(posedge clk) begin
      if (!rst_n)         vol_q <= '0;
      else if (smp_valid) vol_q <= vol_smp;
   end

   rp_mult #(
      .A_W (HC_W),
      .B_W (SMP_W),
      .P_W (PROD_W)
   ) u_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (hc_valid),
      .a         (hc_smp),
      .b         (vol_q),
      .out_valid (pr_valid),
      .p         (pr_word)
   );

   rp_pole_lpf #(
      .IN_W  (PROD_W),
      .SHIFT (LPF_SHIFT),
      .GUARD (GUARD_W)
   ) u_lpf (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pr_valid),
      .in_p      (pr_word),
      .out_valid (pwr_valid),
      .out_p     (pwr_word)
   );

   AST_PIPE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> ##2 pwr_valid); // R2
   AST_PIPE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_valid |-> $past(smp_valid, 3)); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_valid |-> $stable(pwr_word)); // R3
endmodule

// File: tb/rp_power_path_test.sv
module rp_power_path_test;
   localparam int  SMP_W  = 16;
   localparam int  PW     = 32;
   localparam int  PERIOD = 64;
   localparam int  SETTLE = 12000;
   localparam real PI     = 3.14159265358979;

   typedef struct {
      string req;
      real   exp_v;
      real   tol;
   } exp_t;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    smp_valid = 1'b0;
   logic signed [SMP_W-1:0] cur_smp = '0;
   logic signed [SMP_W-1:0] vol_smp = '0;
   logic                    pwr_valid;
   logic signed [PW-1:0]    pwr_word;

   always #10 clk = ~clk;

   rp_power_path #(
      .SMP_W     (SMP_W),
      .HPF_SHIFT (12),
      .LPF_SHIFT (6),
      .GUARD_W   (8),
      .SAT_CUR   (1'b1)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .cur_smp   (cur_smp),
      .vol_smp   (vol_smp),
      .pwr_valid (pwr_valid),
      .pwr_word  (pwr_word)
   );

   exp_t sbq[$];
   int   n_checks = 0;
   int   n_errors = 0;
   int   mon_checks = 0;
   int   mon_errors = 0;
   int   mon_done = 0;
   real  mon_mean = 0.0;
   real  mon_p2p = 0.0;

   // waveform parameters of the running case
   real cA1, cA3, cPh1, cPh3, cIos, vB1, vB3, vVos;
   int  n_idx = 0;

   // monitor: accumulates one line period while an expectation is queued
   real acc_sum = 0.0;
   real acc_min = 0.0;
   real acc_max = 0.0;
   int  acc_cnt = 0;
   always @(negedge clk) begin
      if (sbq.size() > 0 && pwr_valid) begin
         real v;
         v = $itor(pwr_word);
         if (acc_cnt == 0) begin
            acc_min = v;
            acc_max = v;
            acc_sum = 0.0;
         end
         acc_sum += v;
         if (v < acc_min) acc_min = v;
         if (v > acc_max) acc_max = v;
         acc_cnt++;
         if (acc_cnt == PERIOD) begin
            exp_t e;
            real  d;
            e = sbq.pop_front();
            mon_mean = acc_sum / PERIOD;
            mon_p2p  = acc_max - acc_min;
            d = mon_mean - e.exp_v;
            mon_checks++;
            if (d > e.tol || d < -e.tol) begin
               mon_errors++;
               $display("FAIL %s mean actual %0f expected %0f", e.req, mon_mean, e.exp_v);
            end
            acc_cnt = 0;
            mon_done++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input real act, input real exp_v);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual %0f expected %0f", req, act, exp_v);
      end
   endtask

   function automatic logic signed [SMP_W-1:0] to_smp(input real r);
      return SMP_W'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
   endfunction

   task automatic drive_one();
      real th;
      @(negedge clk);
      th = 2.0 * PI * n_idx / PERIOD;
      cur_smp   = to_smp(cIos + cA1 * $sin(th - cPh1) + cA3 * $sin(3.0 * th - cPh3));
      vol_smp   = to_smp(vVos + vB1 * $sin(th) + vB3 * $sin(3.0 * th));
      smp_valid = 1'b1;
      n_idx++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      smp_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_case(input string req, input real a1, input real ph1,
                           input real a3, input real ph3, input real ios,
                           input real b1, input real b3, input real vos,
                           input real exp_v);
      exp_t e;
      int   done0;
      do_reset();
      cA1 = a1; cPh1 = ph1; cA3 = a3; cPh3 = ph3; cIos = ios;
      vB1 = b1; vB3 = b3; vVos = vos;
      n_idx = 0;
      for (int k = 0; k < SETTLE; k++) drive_one();
      done0 = mon_done;
      e.req = req; e.exp_v = exp_v; e.tol = 1.28e6;
      sbq.push_back(e);
      while (mon_done == done0) drive_one();
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic run_all();
      real deg;
      real mean_clean;
      logic signed [PW-1:0] held;
      deg = PI / 180.0;

      // R1: reset state
      repeat (4) @(negedge clk);
      check(pwr_valid == 1'b0, "R1 valid in reset", $itor(pwr_valid), 0.0);
      check(pwr_word == 0, "R1 word in reset", $itor(pwr_word), 0.0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pwr_valid == 1'b0 && pwr_word == 0, "R1 after release", $itor(pwr_word), 0.0);

      // R2: single sample, valid appears after the third edge only
      cur_smp = 16'sd1000; vol_smp = 16'sd1000; smp_valid = 1'b1;
      @(negedge clk); smp_valid = 1'b0;
      @(negedge clk);
      check(pwr_valid == 1'b0, "R2 early valid", $itor(pwr_valid), 0.0);
      @(negedge clk);
      check(pwr_valid == 1'b1, "R2 valid at edge k+3", $itor(pwr_valid), 1.0);
      @(negedge clk);
      check(pwr_valid == 1'b0, "R2 single pulse", $itor(pwr_valid), 0.0);

      // R7 and R9: in phase, no offsets
      run_case("R7 phi=0", 16000.0, 0.0, 0.0, 0.0, 0.0, 16000.0, 0.0, 0.0, 1.28e8);
      mean_clean = mon_mean;
      check(mon_p2p < 2.56e7, "R9 ripple p2p", mon_p2p, 2.56e7);

      // R3: inputs ignored and word held while no sample is accepted
      repeat (4) @(negedge clk);
      held = pwr_word;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         cur_smp = SMP_W'(k * 3001);
         vol_smp = SMP_W'(-k * 2203);
      end
      @(negedge clk);
      check(pwr_word == held && pwr_valid == 1'b0, "R3 hold while idle",
            $itor(pwr_word), $itor(held));

      // R5: offsets on both channels leave the mean unchanged
      run_case("R5 offsets phi=0", 16000.0, 0.0, 0.0, 0.0, 3000.0, 14000.0, 0.0, -1500.0,
               16000.0 * 14000.0 / 2.0);
      check((mon_mean * 16000.0 / 14000.0 - mean_clean) < 1.28e6 &&
            (mon_mean * 16000.0 / 14000.0 - mean_clean) > -1.28e6,
            "R5 offset independence", mon_mean * 16000.0 / 14000.0, mean_clean);

      run_case("R7 phi=60", 16000.0, 60.0 * deg, 0.0, 0.0, 2000.0, 16000.0, 0.0, 0.0, 6.4e7);
      run_case("R7 phi=90", 16000.0, 90.0 * deg, 0.0, 0.0, 0.0, 16000.0, 0.0, 0.0, 0.0);
      run_case("R7 phi=180", 16000.0, 180.0 * deg, 0.0, 0.0, 0.0, 16000.0, 0.0, 0.0, -1.28e8);
      // R6 sign of the product shows in a negative mean at a reversed phase
      check(mon_mean < 0.0, "R6 negative product sign", mon_mean, -1.28e8);

      // R4: constant current, sinusoidal voltage
      run_case("R4 dc current", 0.0, 0.0, 0.0, 0.0, 3000.0, 16000.0, 0.0, 0.0, 0.0);

      // R8: fundamental plus third harmonic, harmonic current lagging 60 degrees
      run_case("R8 harmonics", 12000.0, 0.0, 4000.0, 60.0 * deg, 0.0, 12000.0, 4000.0, 0.0,
               12000.0 * 12000.0 / 2.0 + 4000.0 * 4000.0 * 0.5 / 2.0);
   endtask

   initial begin
      bit wd = 1'b0;
      fork
         run_all();
         begin
            repeat (190000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      disable fork;
      if (wd) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      end
      n_checks += mon_checks;
      n_errors += mon_errors;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule